// File: doc/BRIEF.md
# Register-Mapped SPI Command Engine

This block is a small byte-wide register file that runs a single short serial-flash transaction each time software starts it. Before starting, software fills an opcode register, three address-byte registers and one spare data byte. It then writes a control byte to offset 0. That byte selects how many bytes go out on the wire (1, 2, 4 or 5, counting the opcode) and how many bytes come back (0 to 3).

While the transaction runs, the engine holds chip select low. It shifts the outgoing bytes out MSB first in SPI mode 0, then clocks in the reply bytes and stores them in read-only offsets. Bit 7 of offset 0 reads as busy until the transaction is finished. The serial clock is the system clock divided down by a parameter, `CLK_DIV` system cycles per half period.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, offsets 0 to 7 all read 0x00, `spi_cs_n` is high and `spi_sck` is low.
- R2: A write to offset 0 with bits 7:4 equal to 0x5 starts a transaction. From the cycle after that write, bit 7 of offset 0 reads 1. It stays 1 until one cycle after `spi_cs_n` returns high, and reads 0 from then on.
- R3: Bits 1:0 of the start byte give the number of bytes sent: code 0 sends 1 byte, 1 sends 2, 2 sends 4 and 3 sends 5. Bits 3:2 give the number of bytes read (0 to 3). The transaction gives exactly 8 x (sent + read) SCK pulses.
- R4: Bytes go out MSB first. The opcode (offset 1) is always first. With code 1, the second byte comes from offset 7. With codes 2 and 3, the next three bytes come from offsets 4, 3 and 2, in that order. With code 3, a fifth byte follows from offset 7.
- R5: Read bytes are sampled MSB first after the last sent bit. They are placed at offsets 5, 6 and 7 in arrival order. Offsets not reached by the read count keep their previous contents. MOSI is 0 during the read phase.
- R6: SPI mode 0 is used. SCK is low whenever chip select is inactive. MOSI changes only while SCK is low. Each SCK half period lasts `CLK_DIV` system cycles.
- R7: A write to offset 0 whose bits 7:4 are not 0x5 is ignored. No transaction starts and busy stays 0.
- R8: Every write that arrives while busy is 1 is ignored. Register contents do not change and no second transaction starts.
- R9: `spi_cs_n` goes low on the cycle after the start write. It stays low for exactly 2 x `CLK_DIV` x bits system cycles, with no gap.
- R10: Offsets 1 to 4 read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Busy and chip select are both due at the first falling system-clock edge after the start write. The bench samples them there. From that point it counts the falling edges at which `spi_cs_n` is still low and expects exactly 2 x `CLK_DIV` x bits. At the edge where chip select has returned high, busy must still read 1. One edge later it must read 0, and only then are offsets 5 to 7 read and compared. A monitor checks each frame's MOSI bits and pulse count against a queue filled by the driver. The comparison happens at the moment `spi_cs_n` rises, so an ignored start shows up as an unexpected frame.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int BYTE_W   = 8;
    localparam int MAX_TX   = 5;
    localparam int MAX_RX   = 3;
    localparam int FRAME_W  = MAX_TX * BYTE_W;
    localparam int BITCNT_W = 6;

    localparam logic [3:0] START_TAG = 4'h5;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_OP    = 3'd1;
    localparam logic [2:0] OFS_ADR_A = 3'd2;
    localparam logic [2:0] OFS_RX0   = 3'd5;
    localparam logic [2:0] OFS_EXTRA = 3'd7;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SHIFT,
        SQ_RELEASE
    } sq_state_t;

    typedef struct packed {
        logic [1:0] wcode;
        logic [1:0] rcount;
    } xfer_cfg_t;

    function automatic logic [2:0] tx_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    // Wire-order frame, first byte at the MSB end, unused bytes zero.
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [BYTE_W-1:0] op,
        input logic [BYTE_W-1:0] adr_a,
        input logic [BYTE_W-1:0] adr_b,
        input logic [BYTE_W-1:0] adr_c,
        input logic [BYTE_W-1:0] extra,
        input logic [1:0]        code);
        logic [BYTE_W-1:0] b1, b2, b3, b4;
        b1 = (code == 2'd1) ? extra : ((code[1]) ? adr_c : '0);
        b2 = code[1] ? adr_b : '0;
        b3 = code[1] ? adr_a : '0;
        b4 = (code == 2'd3) ? extra : '0;
        return {op, b1, b2, b3, b4};
    endfunction

endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              busy,
    output logic [BYTE_W-1:0] op_q,
    output logic [BYTE_W-1:0] adr_q [3],
    output logic [BYTE_W-1:0] extra_q,
    output logic              start,
    output xfer_cfg_t         cfg
);

    logic accept;
    assign accept = wr_en && !busy;

    assign start      = accept && (addr == OFS_CTRL) && (wdata[7:4] == START_TAG);
    assign cfg.wcode  = wdata[1:0];
    assign cfg.rcount = wdata[3:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= '0;
            extra_q <= '0;
        end else if (accept) begin
            if (addr == OFS_OP)    op_q    <= wdata;
            if (addr == OFS_EXTRA) extra_q <= wdata;
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_adr
        always_ff @(posedge clk) begin
            if (rst)
                adr_q[g] <= '0;
            else if (accept && addr == OFS_ADR_A + 3'(g))
                adr_q[g] <= wdata;
        end
    end

endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  xfer_cfg_t          cfg,
    input  logic [FRAME_W-1:0] frame,
    input  logic               spi_miso,
    output logic               busy,
    output logic               spi_sck,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    output logic [BYTE_W-1:0]  rx_q [MAX_RX]
);

    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    sq_state_t             state_q;
    logic [DIV_W-1:0]      div_q;
    logic [BITCNT_W-1:0]   bit_q, wbits_q, last_q;
    logic [FRAME_W-1:0]    sr_q;
    logic [1:0]            rx_idx;

    assign spi_mosi = sr_q[FRAME_W-1];
    assign rx_idx   = 2'((bit_q - wbits_q) >> 3);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            div_q    <= '0;
            bit_q    <= '0;
            wbits_q  <= '0;
            last_q   <= '0;
            sr_q     <= '0;
            busy     <= 1'b0;
            spi_sck  <= 1'b0;
            spi_cs_n <= 1'b1;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        state_q  <= SQ_SHIFT;
                        busy     <= 1'b1;
                        spi_cs_n <= 1'b0;
                        div_q    <= '0;
                        bit_q    <= '0;
                        sr_q     <= frame;
                        wbits_q  <= BITCNT_W'({tx_bytes(cfg.wcode), 3'b000});
                        last_q   <= BITCNT_W'({tx_bytes(cfg.wcode), 3'b000})
                                  + BITCNT_W'({cfg.rcount, 3'b000}) - 1'b1;
                    end
                end
                SQ_SHIFT: begin
                    if (div_q == DIV_LAST) begin
                        div_q <= '0;
                        if (!spi_sck) begin
                            spi_sck <= 1'b1;
                        end else begin
                            spi_sck <= 1'b0;
                            if (bit_q == last_q) begin
                                spi_cs_n <= 1'b1;
                                state_q  <= SQ_RELEASE;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                                sr_q  <= sr_q << 1;
                            end
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                SQ_RELEASE: begin
                    busy    <= 1'b0;
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Sample MISO on the system edge that raises SCK, read phase only.
    for (genvar g = 0; g < MAX_RX; g++) begin : g_rx
        always_ff @(posedge clk) begin
            if (rst)
                rx_q[g] <= '0;
            else if (state_q == SQ_SHIFT && div_q == DIV_LAST && !spi_sck
                     && bit_q >= wbits_q && rx_idx == 2'(g))
                rx_q[g] <= {rx_q[g][BYTE_W-2:0], spi_miso};
        end
    end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);

    logic               busy_w, start_w;
    xfer_cfg_t          cfg_w;
    logic [BYTE_W-1:0]  op_w, extra_w;
    logic [BYTE_W-1:0]  adr_w [3];
    logic [BYTE_W-1:0]  rx_w [MAX_RX];
    logic [FRAME_W-1:0] frame_w;

    spi_eng_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .busy    (busy_w),
        .op_q    (op_w),
        .adr_q   (adr_w),
        .extra_q (extra_w),
        .start   (start_w),
        .cfg     (cfg_w)
    );

    assign frame_w = build_frame(op_w, adr_w[0], adr_w[1], adr_w[2], extra_w, cfg_w.wcode);

    spi_eng_seq #(.CLK_DIV(CLK_DIV)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_w),
        .cfg      (cfg_w),
        .frame    (frame_w),
        .spi_miso (spi_miso),
        .busy     (busy_w),
        .spi_sck  (spi_sck),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .rx_q     (rx_w)
    );

    always_comb begin
        case (addr)
            3'd0:    rdata = {busy_w, 7'b0};
            3'd1:    rdata = op_w;
            3'd2:    rdata = adr_w[0];
            3'd3:    rdata = adr_w[1];
            3'd4:    rdata = adr_w[2];
            3'd5:    rdata = rx_w[0];
            3'd6:    rdata = rx_w[1];
            default: rdata = rx_w[2];
        endcase
    end

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic       busy,
    input logic       spi_sck,
    input logic       spi_cs_n,
    input logic       spi_mosi,
    input logic [7:0] op_q
);

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd0 && wdata[7:4] == 4'h5 && !busy) |=> (busy && !spi_cs_n));

    assert_busy_tail_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> busy);

    assert_busy_drop_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |=> !busy);

    assert_bad_tag_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd0 && wdata[7:4] != 4'h5 && !busy) |=> !busy);

    assert_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> $stable(op_q));

    assert_sck_idle_R6: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(spi_sck) && spi_sck) |-> $stable(spi_mosi));

    assert_cs_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy);

endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .busy     (busy_w),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .op_q     (op_w)
);

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;

    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

    always #10 clk = ~clk;

    spi_cmd_engine #(.CLK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int          nbits;
        logic [63:0] bits;
        string       req;
    } frame_t;
    frame_t exp_q[$];

    // Flash model: reply stream indexed by rising edges since chip select fell.
    logic [63:0] pattern = '0;
    logic [63:0] cap = '0;
    int          sck_cnt = 0;
    logic [7:0]  rx_model [3] = '{8'h00, 8'h00, 8'h00};

    assign spi_miso = (sck_cnt < 64) ? pattern[63 - sck_cnt] : 1'b0;

    always @(posedge spi_sck or negedge spi_cs_n) begin
        if (spi_sck) begin
            cap     = {cap[62:0], spi_mosi};
            sck_cnt = sck_cnt + 1;
        end else begin
            cap     = '0;
            sck_cnt = 0;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare each completed frame with the driver's queue.
    always @(posedge spi_cs_n) begin
        if (!rst) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected frame", 64'(sck_cnt), 64'hFFFF);
            end else begin
                frame_t f;
                f = exp_q.pop_front();
                check({f.req, " R3 pulse count"}, 64'(sck_cnt), 64'(f.nbits));
                check({f.req, " R4 R5 mosi bits"}, cap, f.bits);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic int wbytes_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 5;
    endfunction

    task automatic push_frame(input logic [7:0] op, a2, a3, a4, ex, input int code, rc, input string tag);
        frame_t f;
        logic [63:0] v;
        v = 64'(op);
        if (code == 1) v = {v[55:0], ex};
        if (code >= 2) v = {v[39:0], a4, a3, a2};
        if (code == 3) v = {v[55:0], ex};
        v = v << (8 * rc);
        f.nbits = 8 * (wbytes_of(code) + rc);
        f.bits  = v;
        f.req   = tag;
        exp_q.push_back(f);
    endtask

    task automatic run(input logic [7:0] op, a2, a3, a4, ex, input int code, rc,
                       input logic [63:0] pat, input string tag);
        int wb, low;
        logic [7:0] d;
        wr(3'd1, op); wr(3'd2, a2); wr(3'd3, a3); wr(3'd4, a4); wr(3'd7, ex);
        pattern = pat;
        wb = 8 * wbytes_of(code);
        push_frame(op, a2, a3, a4, ex, code, rc, tag);
        wr(3'd0, 8'h50 | 8'(rc << 2) | 8'(code));
        #1;
        check({tag, " R2 busy after start"}, 64'(rdata), 64'h80);
        check({tag, " R9 cs low after start"}, 64'(spi_cs_n), 64'h0);
        low = 0;
        while (spi_cs_n == 1'b0) begin
            low++;
            @(negedge clk); #1;
        end
        check({tag, " R9 cs low cycles"}, 64'(low), 64'(2 * DIV * (wb + 8 * rc)));
        check({tag, " R2 busy held at cs rise"}, 64'(rdata), 64'h80);
        @(negedge clk); #1;
        check({tag, " R2 busy cleared"}, 64'(rdata), 64'h00);
        for (int k = 0; k < rc; k++) rx_model[k] = pat[63 - wb - 8 * k -: 8];
        for (int k = 0; k < 3; k++) begin
            rd(3'(5 + k), d);
            check({tag, " R5 read byte"}, 64'(d), 64'(rx_model[k]));
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 cs idle", 64'(spi_cs_n), 64'h1);
        check("R1 sck idle", 64'(spi_sck), 64'h0);
        for (int k = 0; k < 8; k++) begin
            rd(3'(k), d);
            check("R1 reset register", 64'(d), 64'h0);
        end

        wr(3'd1, 8'hA1); wr(3'd2, 8'hB2); wr(3'd3, 8'hC3); wr(3'd4, 8'hD4);
        rd(3'd1, d); check("R10 readback op", 64'(d), 64'hA1);
        rd(3'd2, d); check("R10 readback ofs2", 64'(d), 64'hB2);
        rd(3'd3, d); check("R10 readback ofs3", 64'(d), 64'hC3);
        rd(3'd4, d); check("R10 readback ofs4", 64'(d), 64'hD4);

        run(8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 0, 3, 64'h5AC3_E781_2468_ACE1, "id read");
        run(8'h06, 8'h11, 8'h22, 8'h33, 8'h44, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "one byte");
        run(8'h35, 8'h11, 8'h22, 8'h33, 8'hE7, 1, 0, 64'h0, "two byte");
        run(8'h20, 8'h56, 8'h34, 8'h12, 8'h99, 2, 0, 64'h0, "four byte");
        run(8'h0B, 8'hCC, 8'hBB, 8'hAA, 8'h3C, 3, 1, 64'h0123_4567_89AB_CDEF, "five byte");
        run(8'h05, 8'h01, 8'h02, 8'h03, 8'h81, 1, 2, 64'hF0E1_D2C3_B4A5_9687, "two in two out");

        // R7: wrong tag in bits 7:4 is ignored.
        wr(3'd0, 8'h3F);
        #1;
        check("R7 no busy", 64'(rdata), 64'h00);
        check("R7 cs stays high", 64'(spi_cs_n), 64'h1);
        repeat (4) @(negedge clk);
        #1;
        check("R7 still idle", 64'(spi_cs_n), 64'h1);

        // R8: writes while busy are dropped.
        wr(3'd1, 8'h42); wr(3'd2, 8'h01); wr(3'd3, 8'h02); wr(3'd4, 8'h03);
        push_frame(8'h42, 8'h01, 8'h02, 8'h03, 8'h00, 2, 0, "locked");
        wr(3'd0, 8'h52);
        wr(3'd1, 8'hEE);
        wr(3'd4, 8'h77);
        wr(3'd0, 8'h5F);
        @(posedge spi_cs_n);
        repeat (6) @(negedge clk);
        rd(3'd1, d); check("R8 op unchanged", 64'(d), 64'h42);
        rd(3'd4, d); check("R8 ofs4 unchanged", 64'(d), 64'h03);
        rd(3'd0, d); check("R8 no second start", 64'(d), 64'h00);
        check("R8 no stray frame", 64'(spi_cs_n), 64'h1);

        repeat (4) @(negedge clk);
        check("R3 all frames seen", 64'(exp_q.size()), 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule